// File: doc/BRIEF.md
# Two-Bank Level-Sensitive Interrupt Controller

This block gathers up to forty level-sensitive interrupt lines into two 32-bit banks. The lower bank holds lines 0 to 31 and the upper bank holds lines 32 to 39 in its low bits. Software works it over a plain synchronous register port. It can enable each line, send each line either to the fast-interrupt output or to the normal-interrupt output, and read back filtered or unfiltered views of the line states. A control bit decides whether a line that is not enabled may still wake a halted core.

Each line also has a priority slot, and there are forty of these. A slot holds a valid flag and a line number. A resolver inside the block walks the slots in order, and slot 0 ranks highest. It reports the first slot that names a line which is both active and enabled, once for the normal output and once for the fast output. Software reads this result as a single word.

Read data is combinational from the address. A register write changes the outputs in the cycle that follows the write edge.

Top module: `irq_bank_ctrl`

## Requirements
- R1: The pending state of each line is its live input level, with no latching. A raw-pending read returns the input bits in the same cycle. Bank 0 raw pending is at byte offset 0x10 and bank 1 raw pending is at 0xAC.
- R2: The enable registers are at 0x04 (bank 0) and 0xA0 (bank 1). The routing registers are at 0x08 (bank 0) and 0xA4 (bank 1). Each stores the written bits for existing lines only, so bank 1 keeps bits 7:0 and reads all higher bits as 0. Both registers reset to 0.
- R3: `fiq_o` is high exactly when some line is high, enabled, and has routing bit 1.
- R4: `irq_o` is high exactly when some line is high, enabled, and has routing bit 0.
- R5: Normal-pending reads return pending AND enabled AND NOT routing. They are at 0x00 (bank 0) and 0x9C (bank 1). Fast-pending reads return pending AND enabled AND routing. They are at 0x0C (bank 0) and 0xA8 (bank 1).
- R6: The wake control register is at 0x14. Bit 0 resets to 1 and is read back in bit 0, with all other bits 0. `wake_o` is 0 while `halted_i` is 0. While halted, `wake_o` follows the value of bit 0:
  - With bit 0 = 1, `wake_o` is 1 when an enabled line is high.
  - With bit 0 = 0, `wake_o` is 1 when any line is high.
- R7: Priority slots 0 to 31 are at 0x1C + 4·n. Slots 32 to 39 are at 0xB0 + 4·(n−32). A write keeps only bit 31 (valid) and bits 5:0 (line number), and every other bit reads as 0. Slots reset to 0.
- R8: The resolver word is read at 0x18.
  - Bits 31 and 21:16 give the normal-interrupt result: a valid flag and a line number.
  - Bits 15 and 5:0 give the fast-interrupt result in the same way.
  - The lowest-numbered slot wins. Only valid slots count, and only if they name a line below 40 that is high, enabled and routed to that output.
  - When no slot qualifies for an output, its flag is 0 and its line field is 0x3F. All other bits are 0.
- R9: Reads at unmapped or non-word-aligned offsets return 0, and writes there change nothing. Writes to any pending register (normal, fast or raw) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Live interrupt line levels |
| halted_i | input | 1 | Core is halted and may be woken |
| addr_i | input | ADDR_W | Byte address of register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
The bench builds the block with its defaults of forty lines and an 8-bit address. This leaves bank 1 only partly filled, so the masking of its upper 24 bits is exercised. Because the 6-bit line field can name lines 40 to 63, the bench can also write slot values that name lines which do not exist and check that the resolver skips them. The bench scans every word-aligned offset up to 0xFC, which covers the gap between 0xD0 and the top of the address space. Random traffic on both banks, the slots and the wake control is compared against a behavioural model on every clock.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   localparam int WORD_W  = 32;
   localparam int BANK_W  = 32;
   localparam int ID_W    = 6;
   localparam int MAX_SRC = 40;
   localparam int IDX_CTRL = 5;
   localparam int IDX_HP   = 6;

   typedef enum int {
      RK_IRQP  = 0,
      RK_MASK  = 1,
      RK_LEVEL = 2,
      RK_FIQP  = 3,
      RK_RAW   = 4
   } bank_reg_e;

   typedef struct packed {
      logic            valid;
      logic [ID_W-1:0] id;
   } prio_t;

   // word index of the first register of a bank
   function automatic int bank_base(input int b);
      return (b == 0) ? 0 : 39;
   endfunction

   // word index of a priority slot
   function automatic int prio_idx(input int p);
      return (p < 32) ? (7 + p) : (44 + p - 32);
   endfunction
endpackage

// File: rtl/irq_bank_regs.sv
module irq_bank_regs #(
   parameter int NUM_SRC = 40,
   parameter int BANKS   = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [31:0]        wdata_i,
   input  logic [BANKS-1:0]   mask_we_i,
   input  logic [BANKS-1:0]   level_we_i,
   input  logic               ctrl_we_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] level_o,
   output logic               only_en_o
);
   import irq_bank_pkg::*;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int LO = b * BANK_W;
      localparam int HI = (NUM_SRC < LO + BANK_W) ? NUM_SRC : LO + BANK_W;
      localparam int W  = HI - LO;
      logic [W-1:0] m_q, l_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            m_q <= '0;
            l_q <= '0;
         end else begin
            if (mask_we_i[b])  m_q <= wdata_i[W-1:0];
            if (level_we_i[b]) l_q <= wdata_i[W-1:0];
         end
      end
      assign mask_o[HI-1:LO]  = m_q;
      assign level_o[HI-1:LO] = l_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        only_en_o <= 1'b1;
      else if (ctrl_we_i) only_en_o <= wdata_i[0];
   end

   // R2: enable bits move only on an enable write
   p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(|mask_we_i) |-> $stable(mask_o));
   // R2: routing bits move only on a routing write
   p_level_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(|level_we_i) |-> $stable(level_o));
endmodule

// File: rtl/irq_bank_prio.sv
module irq_bank_prio #(
   parameter int NUM_SRC = 40
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic [NUM_SRC-1:0]                  we_i,
   input  irq_bank_pkg::prio_t                 wval_i,
   output irq_bank_pkg::prio_t [NUM_SRC-1:0]   prio_o
);
   for (genvar p = 0; p < NUM_SRC; p++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      prio_o[p] <= '0;
         else if (we_i[p]) prio_o[p] <= wval_i;
      end
   end

   // R7: one slot at most is written per cycle
   p_slot_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(we_i));
endmodule

// File: rtl/irq_bank_resolver.sv
module irq_bank_resolver #(
   parameter int NUM_SRC = 40
) (
   input  irq_bank_pkg::prio_t [NUM_SRC-1:0] prio_i,
   input  logic [NUM_SRC-1:0]                act_i,
   input  logic [NUM_SRC-1:0]                level_i,
   output logic [31:0]                       hp_o
);
   import irq_bank_pkg::*;
   localparam int SPAN = 1 << ID_W;

   logic [SPAN-1:0] act_pad, lvl_pad;
   logic            irq_v, fiq_v;
   logic [ID_W-1:0] irq_id, fiq_id;

   always_comb begin
      act_pad = '0;
      lvl_pad = '0;
      act_pad[NUM_SRC-1:0] = act_i;
      lvl_pad[NUM_SRC-1:0] = level_i;
      irq_v  = 1'b0;
      fiq_v  = 1'b0;
      irq_id = '1;
      fiq_id = '1;
      // walk from the lowest rank upward so slot 0 is the last to overwrite
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (prio_i[i].valid && (int'(prio_i[i].id) < NUM_SRC)) begin
            if (act_pad[prio_i[i].id] && lvl_pad[prio_i[i].id]) begin
               fiq_v  = 1'b1;
               fiq_id = prio_i[i].id;
            end
            if (act_pad[prio_i[i].id] && !lvl_pad[prio_i[i].id]) begin
               irq_v  = 1'b1;
               irq_id = prio_i[i].id;
            end
         end
      end
      hp_o = {irq_v, 9'd0, irq_id, fiq_v, 9'd0, fiq_id};
   end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
   parameter int NUM_SRC = 40,
   parameter int ADDR_W  = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               halted_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [31:0]        wdata_i,
   output logic [31:0]        rdata_o,
   output logic               irq_o,
   output logic               fiq_o,
   output logic               wake_o
);
   import irq_bank_pkg::*;

   localparam int BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
   localparam int PAD_W = BANKS * BANK_W;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must lie in 1..40");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic [NUM_SRC-1:0]       mask_q, level_q, act;
   logic                     only_en_q;
   logic [BANKS-1:0]         mask_we, level_we;
   logic                     ctrl_we;
   logic [NUM_SRC-1:0]       prio_we;
   prio_t [NUM_SRC-1:0]      prio_q;
   logic [31:0]              hp_word;
   logic [PAD_W-1:0]         pend_pad, mask_pad, lvl_pad;
   logic                     aligned;
   int                       idx;

   assign aligned = (addr_i[1:0] == 2'b00);
   assign idx     = int'(addr_i[ADDR_W-1:2]);

   assign act    = src_i & mask_q;
   assign fiq_o  = |(act & level_q);
   assign irq_o  = |(act & ~level_q);
   assign wake_o = halted_i & (|(src_i & (mask_q | {NUM_SRC{~only_en_q}})));

   assign pend_pad = PAD_W'(src_i);
   assign mask_pad = PAD_W'(mask_q);
   assign lvl_pad  = PAD_W'(level_q);

   // write strobes
   always_comb begin
      mask_we  = '0;
      level_we = '0;
      ctrl_we  = 1'b0;
      prio_we  = '0;
      if (we_i && aligned) begin
         for (int b = 0; b < BANKS; b++) begin
            if (idx == bank_base(b) + int'(RK_MASK))  mask_we[b]  = 1'b1;
            if (idx == bank_base(b) + int'(RK_LEVEL)) level_we[b] = 1'b1;
         end
         if (idx == IDX_CTRL) ctrl_we = 1'b1;
         for (int p = 0; p < NUM_SRC; p++)
            if (idx == prio_idx(p)) prio_we[p] = 1'b1;
      end
   end

   // read mux
   always_comb begin
      rdata_o = '0;
      if (aligned) begin
         for (int b = 0; b < BANKS; b++) begin
            if (idx == bank_base(b) + int'(RK_IRQP))
               rdata_o = pend_pad[b*BANK_W +: BANK_W] & mask_pad[b*BANK_W +: BANK_W]
                         & ~lvl_pad[b*BANK_W +: BANK_W];
            if (idx == bank_base(b) + int'(RK_FIQP))
               rdata_o = pend_pad[b*BANK_W +: BANK_W] & mask_pad[b*BANK_W +: BANK_W]
                         & lvl_pad[b*BANK_W +: BANK_W];
            if (idx == bank_base(b) + int'(RK_RAW))   rdata_o = pend_pad[b*BANK_W +: BANK_W];
            if (idx == bank_base(b) + int'(RK_MASK))  rdata_o = mask_pad[b*BANK_W +: BANK_W];
            if (idx == bank_base(b) + int'(RK_LEVEL)) rdata_o = lvl_pad[b*BANK_W +: BANK_W];
         end
         if (idx == IDX_CTRL) rdata_o = {31'd0, only_en_q};
         if (idx == IDX_HP)   rdata_o = hp_word;
         for (int p = 0; p < NUM_SRC; p++)
            if (idx == prio_idx(p))
               rdata_o = {prio_q[p].valid, {(WORD_W-1-ID_W){1'b0}}, prio_q[p].id};
      end
   end

   irq_bank_regs #(.NUM_SRC(NUM_SRC), .BANKS(BANKS)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wdata_i    (wdata_i),
      .mask_we_i  (mask_we),
      .level_we_i (level_we),
      .ctrl_we_i  (ctrl_we),
      .mask_o     (mask_q),
      .level_o    (level_q),
      .only_en_o  (only_en_q)
   );

   irq_bank_prio #(.NUM_SRC(NUM_SRC)) u_prio (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (prio_we),
      .wval_i ({wdata_i[31], wdata_i[ID_W-1:0]}),
      .prio_o (prio_q)
   );

   irq_bank_resolver #(.NUM_SRC(NUM_SRC)) u_res (
      .prio_i  (prio_q),
      .act_i   (act),
      .level_i (level_q),
      .hp_o    (hp_word)
   );

   // R8: a reported normal winner implies the normal output is up
   p_hp_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hp_word[31] |-> irq_o);
   // R8: a reported fast winner implies the fast output is up
   p_hp_fiq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hp_word[15] |-> fiq_o);
   // R6: no wake unless halted
   p_wake_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !halted_i |-> !wake_o);
   // R6: a halted core with a live request is always woken
   p_wake_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_i && (irq_o || fiq_o)) |-> wake_o);
endmodule

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [39:0] src = '0;
   logic        halted = 0;
   logic [7:0]  addr = '0;
   logic        we = 0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq, wake;

   int checks = 0;
   int failures = 0;
   bit chk_on = 0;
   bit timeout = 0;

   // reference state
   bit [39:0] m_mask, m_lvl;
   bit        m_only;
   bit        m_pv [40];
   int        m_pid [40];

   always #10 clk = ~clk;

   irq_bank_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .halted_i(halted),
      .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
      .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
   );

   task automatic model_reset();
      m_mask = '0; m_lvl = '0; m_only = 1;
      for (int i = 0; i < 40; i++) begin m_pv[i] = 0; m_pid[i] = 0; end
   endtask

   task automatic model_write(input bit [7:0] a, input bit [31:0] d);
      case (a)
         8'h04: m_mask[31:0]  = d;
         8'hA0: m_mask[39:32] = d[7:0];
         8'h08: m_lvl[31:0]   = d;
         8'hA4: m_lvl[39:32]  = d[7:0];
         8'h14: m_only        = d[0];
         default: begin
            if (a[1:0] == 0 && a >= 8'h1C && a <= 8'h98) begin
               m_pv[(a - 8'h1C) / 4] = d[31]; m_pid[(a - 8'h1C) / 4] = int'(d[5:0]);
            end else if (a[1:0] == 0 && a >= 8'hB0 && a <= 8'hCC) begin
               m_pv[32 + (a - 8'hB0) / 4] = d[31]; m_pid[32 + (a - 8'hB0) / 4] = int'(d[5:0]);
            end
         end
      endcase
   endtask

   function automatic bit [31:0] exp_hp();
      bit [39:0] a = src & m_mask;
      bit irqv = 0, fiqv = 0;
      int irqid = 63, fiqid = 63;
      for (int p = 0; p < 40; p++) begin
         if (m_pv[p] && m_pid[p] < 40 && a[m_pid[p]]) begin
            if (m_lvl[m_pid[p]] && !fiqv) begin fiqv = 1; fiqid = m_pid[p]; end
            if (!m_lvl[m_pid[p]] && !irqv) begin irqv = 1; irqid = m_pid[p]; end
         end
      end
      return (32'(irqv) << 31) | (32'(irqid) << 16) | (32'(fiqv) << 15) | 32'(fiqid);
   endfunction

   function automatic bit [31:0] exp_rd(input bit [7:0] a);
      bit [39:0] a_irq = src & m_mask & ~m_lvl;
      bit [39:0] a_fiq = src & m_mask & m_lvl;
      if (a[1:0] != 0) return 0;
      case (a)
         8'h10: return src[31:0];
         8'hAC: return {24'd0, src[39:32]};
         8'h04: return m_mask[31:0];
         8'hA0: return {24'd0, m_mask[39:32]};
         8'h08: return m_lvl[31:0];
         8'hA4: return {24'd0, m_lvl[39:32]};
         8'h00: return a_irq[31:0];
         8'h9C: return {24'd0, a_irq[39:32]};
         8'h0C: return a_fiq[31:0];
         8'hA8: return {24'd0, a_fiq[39:32]};
         8'h14: return {31'd0, m_only};
         8'h18: return exp_hp();
         default: begin
            int p = -1;
            if (a >= 8'h1C && a <= 8'h98) p = (a - 8'h1C) / 4;
            if (a >= 8'hB0 && a <= 8'hCC) p = 32 + (a - 8'hB0) / 4;
            if (p < 0) return 0;
            return {m_pv[p], 25'd0, 6'(m_pid[p])};
         end
      endcase
   endfunction

   task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (chk_on) begin
         check("R3 fiq_o", 32'(fiq), 32'(|(src & m_mask & m_lvl)));
         check("R4 irq_o", 32'(irq), 32'(|(src & m_mask & ~m_lvl)));
         check("R6 wake_o", 32'(wake),
               32'(halted && (m_only ? |(src & m_mask) : |src)));
         check("R9 rdata_o", rdata, exp_rd(addr));
      end
   end

   task automatic wr(input bit [7:0] a, input bit [31:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; we = 1;
      @(posedge clk); #1;
      model_write(a, d);
      we = 0;
   endtask

   task automatic rd_chk(input bit [7:0] a, input string tag);
      @(posedge clk); #1;
      addr = a;
      @(negedge clk);
      check(tag, rdata, exp_rd(a));
   endtask

   task automatic set_src(input bit [39:0] s, input bit h);
      @(posedge clk); #1;
      src = s; halted = h;
   endtask

   task automatic run_tests();
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      chk_on = 1;
      // reset state
      rd_chk(8'h04, "R2 reset mask0");
      rd_chk(8'hA4, "R2 reset level1");
      rd_chk(8'h14, "R6 reset ctrl");
      rd_chk(8'h18, "R8 reset resolver");
      rd_chk(8'hB4, "R7 reset slot33");
      // live pending
      set_src(40'hA5_1234_5678, 0);
      rd_chk(8'h10, "R1 raw0");
      rd_chk(8'hAC, "R1 raw1");
      set_src(40'h00_0000_0000, 0);
      rd_chk(8'h10, "R1 raw0 cleared");
      // enable and routing, bank 1 width
      wr(8'h04, 32'hFFFF_0000);
      wr(8'hA0, 32'hFFFF_FFFF);
      rd_chk(8'hA0, "R2 mask1 upper bits zero");
      wr(8'h08, 32'h00FF_00FF);
      wr(8'hA4, 32'h0000_00F0);
      set_src(40'hFF_FFFF_FFFF, 0);
      rd_chk(8'h00, "R5 irq pending0");
      rd_chk(8'h0C, "R5 fiq pending0");
      rd_chk(8'h9C, "R5 irq pending1");
      rd_chk(8'hA8, "R5 fiq pending1");
      // pending writes ignored
      wr(8'h10, 32'h0);
      wr(8'h00, 32'h0);
      rd_chk(8'h10, "R9 raw write ignored");
      // wake behaviour
      set_src(40'h00_0000_0001, 1);
      rd_chk(8'h14, "R6 ctrl only-enabled");
      wr(8'h14, 32'hFFFF_FFFE);
      rd_chk(8'h14, "R6 ctrl any-line");
      set_src(40'h00_0000_0001, 0);
      wr(8'h14, 32'h1);
      // priority slots
      wr(8'h1C, 32'hFFFF_FFFF);
      rd_chk(8'h1C, "R7 slot0 kept bits");
      wr(8'h1C, 32'h8000_0021);
      wr(8'h20, 32'h8000_0010);
      wr(8'hCC, 32'h8000_0027);
      wr(8'h24, 32'h8000_0030);
      set_src(40'hFF_FFFF_FFFF, 0);
      rd_chk(8'h18, "R8 both winners");
      set_src(40'h80_0000_0000, 0);
      rd_chk(8'h18, "R8 slot39 only");
      // unmapped and misaligned
      wr(8'hD0, 32'hFFFF_FFFF);
      wr(8'h05, 32'h0);
      rd_chk(8'h04, "R9 mask after bad writes");
      rd_chk(8'hD0, "R9 unmapped read");
      rd_chk(8'h06, "R9 misaligned read");
      for (int a = 0; a < 256; a += 4) rd_chk(8'(a), "R9 address scan");
      // random traffic
      for (int n = 0; n < 400; n++) begin
         bit [7:0] a;
         case ($urandom_range(0, 6))
            0: a = 8'h04; 1: a = 8'hA0; 2: a = 8'h08; 3: a = 8'hA4;
            4: a = 8'h14;
            5: a = 8'h1C + 8'($urandom_range(0, 31) * 4);
            default: a = 8'hB0 + 8'($urandom_range(0, 7) * 4);
         endcase
         set_src({$urandom, $urandom} & ($urandom_range(0, 1) ? 40'hFF_FFFF_FFFF : 40'h00_0F0F_0F0F),
                 1'($urandom));
         wr(a, $urandom_range(0, 3) == 0 ? ($urandom | 32'h8000_0000) : $urandom & 32'h8000_003F);
         rd_chk(8'h18, "R8 random resolver");
         rd_chk(8'($urandom_range(0, 63) * 4), "R5 random read");
      end
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            timeout = 1;
         end
      join_any
      if (timeout) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      end
      chk_on = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule